// File: doc/BRIEF.md
# Card Reader Programmed-I/O Interface

This block attaches a punched-card reader to the programmed I/O bus of a 12-bit minicomputer. The processor talks to it with I/O transfer instructions. Each instruction carries an opcode, a six-bit device code and a pulse pattern. The block answers two device codes. On each code it can test a flag for a skip, gate a card column onto the accumulator input bus, or select a data format. Selecting a format also orders the reader to feed the next card.

The reader delivers one 12-bit column per strobe. The strobe also brings the column's 6-bit character code, which an external translation table produces. The block latches both at once and raises a column-data flag, and that flag drives the interrupt request. A read returns either the raw column or the 6-bit code in the low half, depending on the stored format.

The card does not stop while it passes the read station. The program therefore has a fixed number of cycles to read each column. A sticky status bit records a column that was not read in time. A second sticky bit records a column that overwrote one still waiting to be read.

Top module: `cardrd_iot_if`

## Requirements
- R1: After reset the ready flag, column-data flag, format (alphanumeric), overrun bit, missed bit, feed request and interrupt request are all 0.
- R2: Instruction octal 6701 with IOP1 raises skip in that same cycle only if three things hold: the ready flag is set, a card is at the read station and the reader has power.
- R3: The ready flag is set by a card-end pulse and cleared by either select instruction. If both arrive in the same cycle, the select wins.
- R4: A column strobe latches the 12 column bits and the 6-bit code. The column-data flag reads 1 from the next cycle, and the interrupt request equals the column-data flag.
- R5: Instruction octal 6741 with IOP1 raises skip in that same cycle exactly when the column-data flag is set.
- R6: IOP2 with octal 6702 or 6742 presents the latched value in that same cycle and clears the column-data flag at the next edge. A strobe in the same cycle sets the flag anyway.
- R7: In alphanumeric format a read gives the code on bus bits [5:0] (accumulator bits 6-11) and zeros on [11:6]. In binary format a read gives column bits [11:0], with bus bit 11 as accumulator bit 0.
- R8: IOP4 with octal 6704 selects alphanumeric format and 6744 selects binary. Either one raises the feed request for exactly the following cycle and clears the overrun and missed bits.
- R9: The accumulator input bus is all zeros in every cycle without a matching read pulse.
- R10: A strobe while the column-data flag is set, with no read or select in that cycle, sets the overrun bit. The new column replaces the old one.
- R11: The missed bit sets if the column-data flag has been set for WINDOW_CYC cycles without a read or new strobe. A read in the WINDOW_CYC-th cycle after the flag rises is on time.
- R12: Pulses whose opcode field (bits [11:9]) is not 6, or whose device field (bits [8:3]) is neither 70 nor 74, change no output and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_i | input | 12 | Instruction word from the memory buffer |
| iop1_i | input | 1 | Skip-test pulse, one cycle |
| iop2_i | input | 1 | Read pulse, one cycle |
| iop4_i | input | 1 | Select pulse, one cycle |
| card_present_i | input | 1 | Card is at the read station |
| rdr_power_i | input | 1 | Reader power is on |
| col_stb_i | input | 1 | New column available, one cycle |
| col_bits_i | input | 12 | Raw column bits |
| col_code_i | input | 6 | Translated 6-bit character code for the column |
| card_end_i | input | 1 | Last column of the card has passed |
| ac_o | output | 12 | Accumulator input bus, ORed with other devices |
| skip_o | output | 1 | Skip request |
| int_req_o | output | 1 | Program interrupt request |
| feed_req_o | output | 1 | Command to feed the next card |
| overrun_o | output | 1 | Sticky: a column was overwritten before it was read |
| missed_o | output | 1 | Sticky: the read window expired |

## Verification
The bench aims at the edges of the read window. A read in the very last allowed cycle must leave the missed bit clear, and one cycle of idleness more must set it. A counter off by one fails one of these two checks. The bench also sends a strobe and a read in the same cycle. A design that lets the clear win would lose that column, and one that flags an overrun there would report a false error. It drives read and skip pulses with wrong opcodes or device codes, and a loose decoder would put data on the shared bus or skip. It also checks that the alphanumeric format zeroes the upper half of the bus, which a plain column pass-through would leave dirty.

// File: rtl/cardrd_pkg.sv
package cardrd_pkg;
    localparam int COL_W  = 12;
    localparam int CODE_W = 6;
    localparam int DEV_W  = 6;
    localparam int WORD_W = 12;

    localparam logic [2:0]       IOT_OPC   = 3'o6;
    localparam logic [DEV_W-1:0] DEV_CTRL  = 6'o70;
    localparam logic [DEV_W-1:0] DEV_DATA  = 6'o74;

    typedef enum logic {
        FMT_ALPHA = 1'b0,
        FMT_BIN   = 1'b1
    } fmt_e;

    typedef struct packed {
        logic skip_rdy;
        logic skip_dat;
        logic rd;
        logic sel;
        fmt_e sel_fmt;
    } iot_cmd_t;

    typedef struct packed {
        logic [COL_W-1:0]  bits;
        logic [CODE_W-1:0] code;
    } column_t;

    function automatic logic is_iot(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: 3] == IOT_OPC;
    endfunction

    function automatic logic [DEV_W-1:0] dev_of(input logic [WORD_W-1:0] w);
        return w[WORD_W-4 -: DEV_W];
    endfunction
endpackage

// File: rtl/cardrd_decode.sv
module cardrd_decode
    import cardrd_pkg::*;
(
    input  logic [WORD_W-1:0] mb,
    input  logic              iop1,
    input  logic              iop2,
    input  logic              iop4,
    output iot_cmd_t          cmd
);
    logic hit_ctrl;
    logic hit_data;

    always_comb begin
        hit_ctrl     = is_iot(mb) && (dev_of(mb) == DEV_CTRL);
        hit_data     = is_iot(mb) && (dev_of(mb) == DEV_DATA);
        cmd.skip_rdy = iop1 && hit_ctrl;
        cmd.skip_dat = iop1 && hit_data;
        cmd.rd       = iop2 && (hit_ctrl || hit_data);
        cmd.sel      = iop4 && (hit_ctrl || hit_data);
        cmd.sel_fmt  = hit_data ? FMT_BIN : FMT_ALPHA;
    end
endmodule

// File: rtl/cardrd_flags.sv
module cardrd_flags
    import cardrd_pkg::*;
#(
    parameter int WINDOW_CYC = 300
) (
    input  logic     clk,
    input  logic     rst,
    input  iot_cmd_t cmd,
    input  logic     col_stb,
    input  logic     card_end,
    output logic     rdy_flag,
    output logic     dat_flag,
    output fmt_e     fmt,
    output logic     feed_req,
    output logic     overrun,
    output logic     missed
);
    localparam int CNT_W = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW_CYC - 1);

    logic [CNT_W-1:0] win_cnt;
    logic             win_end;

    assign win_end = dat_flag && (win_cnt == CNT_LAST) && !cmd.rd && !col_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_flag <= 1'b0;
            fmt      <= FMT_ALPHA;
            feed_req <= 1'b0;
        end else begin
            feed_req <= cmd.sel;
            if (cmd.sel) begin
                rdy_flag <= 1'b0;
                fmt      <= cmd.sel_fmt;
            end else if (card_end) begin
                rdy_flag <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_flag <= 1'b0;
            win_cnt  <= '0;
        end else begin
            if (col_stb) begin
                dat_flag <= 1'b1;
                win_cnt  <= '0;
            end else if (cmd.rd) begin
                dat_flag <= 1'b0;
                win_cnt  <= '0;
            end else if (dat_flag && win_cnt != CNT_LAST) begin
                win_cnt  <= win_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun <= 1'b0;
            missed  <= 1'b0;
        end else begin
            if (col_stb && dat_flag && !cmd.rd && !cmd.sel)
                overrun <= 1'b1;
            else if (cmd.sel)
                overrun <= 1'b0;
            if (win_end && !cmd.sel)
                missed <= 1'b1;
            else if (cmd.sel)
                missed <= 1'b0;
        end
    end
endmodule

// File: rtl/cardrd_colpath.sv
module cardrd_colpath
    import cardrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              col_stb,
    input  column_t           col_in,
    input  logic              rd,
    input  fmt_e              fmt,
    output logic [WORD_W-1:0] ac
);
    column_t col_q;

    always_ff @(posedge clk) begin
        if (rst)
            col_q <= '0;
        else if (col_stb)
            col_q <= col_in;
    end

    always_comb begin
        ac = '0;
        if (rd) begin
            if (fmt == FMT_BIN)
                ac = col_q.bits;
            else
                ac = {{(WORD_W-CODE_W){1'b0}}, col_q.code};
        end
    end
endmodule

// File: rtl/cardrd_iot_if.sv
module cardrd_iot_if
    import cardrd_pkg::*;
#(
    parameter int WINDOW_CYC = 300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] mb_i,
    input  logic              iop1_i,
    input  logic              iop2_i,
    input  logic              iop4_i,
    input  logic              card_present_i,
    input  logic              rdr_power_i,
    input  logic              col_stb_i,
    input  logic [COL_W-1:0]  col_bits_i,
    input  logic [CODE_W-1:0] col_code_i,
    input  logic              card_end_i,
    output logic [WORD_W-1:0] ac_o,
    output logic              skip_o,
    output logic              int_req_o,
    output logic              feed_req_o,
    output logic              overrun_o,
    output logic              missed_o
);
    iot_cmd_t cmd;
    column_t  col_in;
    fmt_e     fmt;
    logic     rdy_flag;
    logic     dat_flag;

    assign col_in.bits = col_bits_i;
    assign col_in.code = col_code_i;

    cardrd_decode u_dec (
        .mb   (mb_i),
        .iop1 (iop1_i),
        .iop2 (iop2_i),
        .iop4 (iop4_i),
        .cmd  (cmd)
    );

    cardrd_flags #(.WINDOW_CYC(WINDOW_CYC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .col_stb  (col_stb_i),
        .card_end (card_end_i),
        .rdy_flag (rdy_flag),
        .dat_flag (dat_flag),
        .fmt      (fmt),
        .feed_req (feed_req_o),
        .overrun  (overrun_o),
        .missed   (missed_o)
    );

    cardrd_colpath u_col (
        .clk     (clk),
        .rst     (rst),
        .col_stb (col_stb_i),
        .col_in  (col_in),
        .rd      (cmd.rd),
        .fmt     (fmt),
        .ac      (ac_o)
    );

    assign skip_o = (cmd.skip_rdy && rdy_flag && card_present_i && rdr_power_i)
                 || (cmd.skip_dat && dat_flag);
    assign int_req_o = dat_flag;
endmodule

// File: rtl/cardrd_iot_if_chk.sv
module cardrd_iot_if_chk
    import cardrd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] mb_i,
    input logic              iop1_i,
    input logic              iop2_i,
    input logic              iop4_i,
    input logic              card_present_i,
    input logic              rdr_power_i,
    input logic              col_stb_i,
    input logic [WORD_W-1:0] ac_o,
    input logic              skip_o,
    input logic              int_req_o,
    input logic              feed_req_o,
    input logic              overrun_o
);
    logic our_dev;
    logic rd_p;
    logic sel_p;
    assign our_dev = (mb_i[11:9] == 3'o6) && (mb_i[8:3] == 6'o70 || mb_i[8:3] == 6'o74);
    assign rd_p    = iop2_i && our_dev;
    assign sel_p   = iop4_i && our_dev;

    // R9
    bus_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_p |-> ac_o == '0);

    // R4
    strobe_sets_int_chk: assert property (@(posedge clk) disable iff (rst)
        col_stb_i |=> int_req_o);

    // R6
    read_clears_int_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_p && !col_stb_i) |=> !int_req_o);

    // R8
    feed_after_sel_chk: assert property (@(posedge clk) disable iff (rst)
        sel_p |=> feed_req_o);

    // R8
    feed_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_p |=> !feed_req_o);

    // R2
    ready_skip_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (skip_o && mb_i[8:3] == 6'o70) |-> (card_present_i && rdr_power_i));

    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (col_stb_i && int_req_o && !rd_p && !sel_p) |=> overrun_o);

    // R12
    skip_needs_iot_chk: assert property (@(posedge clk) disable iff (rst)
        skip_o |-> (iop1_i && our_dev));
endmodule

bind cardrd_iot_if cardrd_iot_if_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .mb_i           (mb_i),
    .iop1_i         (iop1_i),
    .iop2_i         (iop2_i),
    .iop4_i         (iop4_i),
    .card_present_i (card_present_i),
    .rdr_power_i    (rdr_power_i),
    .col_stb_i      (col_stb_i),
    .ac_o           (ac_o),
    .skip_o         (skip_o),
    .int_req_o      (int_req_o),
    .feed_req_o     (feed_req_o),
    .overrun_o      (overrun_o)
);

// File: tb/cardrd_iot_if_tb.sv
module cardrd_iot_if_tb;
    localparam int W = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mb_i = '0;
    logic        iop1_i = 0, iop2_i = 0, iop4_i = 0;
    logic        card_present_i = 0, rdr_power_i = 0;
    logic        col_stb_i = 0;
    logic [11:0] col_bits_i = '0;
    logic [5:0]  col_code_i = '0;
    logic        card_end_i = 0;
    logic [11:0] ac_o;
    logic        skip_o, int_req_o, feed_req_o, overrun_o, missed_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cardrd_iot_if #(.WINDOW_CYC(W)) u_dut (
        .clk(clk), .rst(rst), .mb_i(mb_i),
        .iop1_i(iop1_i), .iop2_i(iop2_i), .iop4_i(iop4_i),
        .card_present_i(card_present_i), .rdr_power_i(rdr_power_i),
        .col_stb_i(col_stb_i), .col_bits_i(col_bits_i), .col_code_i(col_code_i),
        .card_end_i(card_end_i),
        .ac_o(ac_o), .skip_o(skip_o), .int_req_o(int_req_o),
        .feed_req_o(feed_req_o), .overrun_o(overrun_o), .missed_o(missed_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // caller is at a negedge; drive the pulse for one cycle, sample mid-cycle
    task automatic iot(input logic [11:0] code, input int which,
                       output logic sk, output logic [11:0] ac);
        mb_i = code;
        iop1_i = (which == 1);
        iop2_i = (which == 2);
        iop4_i = (which == 4);
        #1;
        sk = skip_o;
        ac = ac_o;
        @(negedge clk);
        iop1_i = 0; iop2_i = 0; iop4_i = 0; mb_i = '0;
    endtask

    task automatic strobe(input logic [11:0] bits, input logic [5:0] code);
        col_stb_i = 1; col_bits_i = bits; col_code_i = code;
        @(negedge clk);
        col_stb_i = 0;
    endtask

    task automatic t_reset();
        check("R1 ac", ac_o, 0);
        check("R1 int", int_req_o, 0);
        check("R1 feed", feed_req_o, 0);
        check("R1 overrun", overrun_o, 0);
        check("R1 missed", missed_o, 0);
    endtask

    task automatic t_ready_skip();
        logic sk; logic [11:0] ac;
        card_present_i = 1; rdr_power_i = 1;
        iot(12'o6701, 1, sk, ac);
        check("R1 ready flag clear", sk, 0);
        card_end_i = 1; @(negedge clk); card_end_i = 0;
        iot(12'o6701, 1, sk, ac);
        check("R2 R3 ready skip", sk, 1);
        rdr_power_i = 0;
        iot(12'o6701, 1, sk, ac);
        check("R2 no power", sk, 0);
        rdr_power_i = 1; card_present_i = 0;
        iot(12'o6701, 1, sk, ac);
        check("R2 no card", sk, 0);
        card_present_i = 1;
    endtask

    task automatic t_select_alpha();
        logic sk; logic [11:0] ac;
        iot(12'o6704, 4, sk, ac);
        check("R8 feed pulse", feed_req_o, 1);
        @(negedge clk);
        check("R8 feed one cycle", feed_req_o, 0);
        iot(12'o6701, 1, sk, ac);
        check("R3 select clears ready", sk, 0);
    endtask

    task automatic t_alpha_read();
        logic sk; logic [11:0] ac;
        strobe(12'o5252, 6'o27);
        check("R4 int after strobe", int_req_o, 1);
        check("R9 bus idle", ac_o, 0);
        iot(12'o6741, 1, sk, ac);
        check("R5 data skip", sk, 1);
        iot(12'o6702, 2, sk, ac);
        check("R7 alpha value", ac, 12'o0027);
        check("R6 flag cleared", int_req_o, 0);
        iot(12'o6741, 1, sk, ac);
        check("R5 no skip when clear", sk, 0);
    endtask

    task automatic t_foreign();
        logic sk; logic [11:0] ac;
        strobe(12'o1111, 6'o11);
        iot(12'o6712, 2, sk, ac);
        check("R12 other device ac", ac, 0);
        check("R12 other device flag", int_req_o, 1);
        iot(12'o5741, 1, sk, ac);
        check("R12 wrong opcode skip", sk, 0);
        iot(12'o5742, 2, sk, ac);
        check("R12 wrong opcode ac", ac, 0);
        iot(12'o6744 & 12'o7707 | 12'o0060, 4, sk, ac); // device 76
        check("R12 other device no feed", feed_req_o, 0);
        iot(12'o6702, 2, sk, ac);
        check("R7 still alpha", ac, 12'o0011);
    endtask

    task automatic t_binary();
        logic sk; logic [11:0] ac;
        iot(12'o6744, 4, sk, ac);
        check("R8 binary feed", feed_req_o, 1);
        strobe(12'o7341, 6'o55);
        iot(12'o6742, 2, sk, ac);
        check("R7 binary value", ac, 12'o7341);
        check("R6 alt read clears", int_req_o, 0);
    endtask

    task automatic t_overrun();
        logic sk; logic [11:0] ac;
        strobe(12'o0101, 6'o01);
        strobe(12'o0202, 6'o02);
        check("R10 overrun set", overrun_o, 1);
        iot(12'o6702, 2, sk, ac);
        check("R10 newest column", ac, 12'o0202);
        iot(12'o6744, 4, sk, ac);
        check("R8 select clears overrun", overrun_o, 0);
        strobe(12'o0303, 6'o03);
        col_stb_i = 1; col_bits_i = 12'o0404; mb_i = 12'o6702; iop2_i = 1;
        @(negedge clk);
        col_stb_i = 0; iop2_i = 0; mb_i = '0;
        check("R6 strobe beats clear", int_req_o, 1);
        check("R10 no overrun on read", overrun_o, 0);
        iot(12'o6702, 2, sk, ac);
        check("R4 latched same-cycle column", ac, 12'o0404);
    endtask

    task automatic t_window();
        logic sk; logic [11:0] ac;
        iot(12'o6744, 4, sk, ac);
        strobe(12'o0707, 6'o07);
        repeat (W-1) @(negedge clk);
        iot(12'o6742, 2, sk, ac);
        check("R11 last-cycle read on time", missed_o, 0);
        strobe(12'o0606, 6'o06);
        repeat (W-1) @(negedge clk);
        check("R11 not yet missed", missed_o, 0);
        @(negedge clk);
        check("R11 missed", missed_o, 1);
        iot(12'o6704, 4, sk, ac);
        check("R8 select clears missed", missed_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_ready_skip();
        t_select_alpha();
        t_alpha_read();
        t_foreign();
        t_binary();
        t_overrun();
        t_window();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule